// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises characters onto an asynchronous serial line. A one-character holding register sits in front of a frame shift register, so the bus side can queue the next character while the current one is still going out. Frames carry 8 or 9 data bits between a low start bit and a high stop bit. An external per-bit baud tick sets the pace, and every line bit lasts exactly one tick interval. Characters written while a frame is in flight follow the current stop bit with no idle gap.

The bus side loads characters over a valid/ready stream. `wr_ready` is high only when the transmitter is enabled and the holding register is empty. A character is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the source must hold `wr_valid` and `wr_data` until it sees ready. Writes are never dropped and never overwrite a queued character. Two plain status pins report "holding register empty" and "transmission complete". An enable input chooses whether the UART or a general-purpose output value drives the pin, and the same input decides whether the pin is forced to output.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `hold_empty` is 1, `tx_done` is 0, and the serial line is idle high whenever `tx_en` is 1.
- R2: `wr_ready` equals `tx_en AND hold_empty`. A character is accepted only on an edge where `wr_valid` and `wr_ready` are both high. `hold_empty` is 0 in the cycle after acceptance, and a queued character is never overwritten.
- R3: In 8-bit mode (`nine_bit_mode`=0), a frame is 10 line bits: start 0, data bits 0..7 least significant first, stop 1. In 9-bit mode, a frame is 11 line bits, and the tenth bit is `tx_bit8`. The mode and `tx_bit8` are sampled when the shifter loads.
- R4: A character accepted while the shifter is idle loads on the next clock edge, and `hold_empty` returns to 1 at that edge. The line stays high until the next baud tick, which drives the start bit. Each later tick drives the next bit.
- R5: A character waiting in the holding register loads at the tick that places the current stop bit on the line, and `hold_empty` rises at that edge. Its start bit follows at the next tick, so the stop bit lasts one bit time.
- R6: A character accepted while a stop bit is on the line, before completion, loads on the next clock edge without waiting for a tick. `tx_done` does not set in this case.
- R7: `tx_done` sets at the tick one bit time after the stop bit was placed on the line, provided no character is waiting. It then stays set.
- R8: `tx_done` clears on a `tc_clr` pulse and also on any accepted write. A clear wins over a set in the same cycle.
- R9: With `tx_en`=1, `pin_oe`=1 and `pin_out` carries the serial line. With `tx_en`=0, `pin_out`=`gpio_out` and `pin_oe`=`gpio_oe`.
- R10: Dropping `tx_en` aborts any frame, returns the line to idle high, and discards a waiting character. After `tx_en` returns, no part of the aborted frames is sent.
- R11: The serial line is high whenever no frame is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable and pin takeover |
| nine_bit_mode | input | 1 | 1 selects 9 data bits per frame |
| tx_bit8 | input | 1 | Ninth data bit used in 9-bit mode |
| wr_valid | input | 1 | Character write request |
| wr_ready | output | 1 | Holding register can take a character |
| wr_data | input | DATA_W | Character to send |
| tc_clr | input | 1 | Pulse that clears the complete flag |
| gpio_out | input | 1 | General-purpose pin value when disabled |
| gpio_oe | input | 1 | General-purpose pin direction when disabled |
| hold_empty | output | 1 | Holding register is empty |
| tx_done | output | 1 | Transmission complete flag |
| pin_out | output | 1 | Value driven onto the serial pin |
| pin_oe | output | 1 | Output enable for the serial pin |

## Verification
The bench targets three boundaries. The first is a character queued mid-frame: a design that reloads too early would cut the stop bit short, and one that reloads too late would leave an idle gap or raise `hold_empty` at the wrong tick. The second is a character written while the stop bit is on the line: a wrong design would wait for a tick before loading or would raise `tx_done` anyway. The third is an abort: dropping enable mid-frame with a character queued must lose both characters and hand the pin over, and a faulty design would resume or leak the pending character after re-enable. The bench also separates the ninth bit from the stop bit by sending `tx_bit8`=0, and it holds a write against back-pressure to catch an overwrite of the queued character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_RUN  = 2'd1,
    SH_STOP = 2'd2
  } shift_state_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              wr_accept
);

  assign wr_ready  = tx_en && !hold_full;
  assign wr_accept = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (!tx_en) begin
      hold_full <= 1'b0;
    end else if (wr_accept) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  // R2: an accepted character occupies the register on the next cycle
  a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> hold_full);

  // R4: a transfer into the shifter frees the register
  a_r4_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tx_en) |=> !hold_full);

  // R10: disabling discards the queued character
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !hold_full);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              nine_bit_mode,
  input  logic              tx_bit8,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              done_set,
  output logic              line
);

  localparam int SR_W = DATA_W + 3;
  localparam int CW   = $clog2(DATA_W + 4);
  localparam logic [CW-1:0] LEN_SHORT = CW'(DATA_W + 2);
  localparam logic [CW-1:0] LEN_LONG  = CW'(DATA_W + 3);

  shift_state_e    state;
  logic [SR_W-1:0] sr;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   len_q;
  logic            last_bit;
  logic [SR_W-1:0] sr_load;
  logic [CW-1:0]   len_load;

  assign last_bit = (state == SH_RUN) && baud_tick && (cnt == CW'(1));
  assign take     = tx_en && hold_full &&
                    ((state == SH_IDLE) || (state == SH_STOP) || last_bit);
  assign done_set = tx_en && (state == SH_STOP) && baud_tick && !hold_full;

  always_comb begin
    sr_load  = {1'b1, (nine_bit_mode ? tx_bit8 : 1'b1), hold_data, 1'b0};
    len_load = nine_bit_mode ? LEN_LONG : LEN_SHORT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      state <= SH_IDLE;
      sr    <= '1;
      cnt   <= '0;
      len_q <= LEN_SHORT;
      line  <= 1'b1;
    end else begin
      if ((state == SH_RUN) && baud_tick) begin
        line <= sr[0];
        sr   <= {1'b1, sr[SR_W-1:1]};
        cnt  <= cnt - CW'(1);
      end
      if (take) begin
        sr    <= sr_load;
        cnt   <= len_load;
        len_q <= len_load;
        state <= SH_RUN;
      end else if (last_bit) begin
        state <= SH_STOP;
      end else if ((state == SH_STOP) && baud_tick) begin
        state <= SH_IDLE;
      end
    end
  end

  // R4: the first tick of a loaded frame drives the start bit
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && state == SH_RUN && baud_tick && cnt == len_q) |=> !line);

  // R3: the final bit of every frame is a high stop bit
  a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && last_bit) |=> line);

  // R11: idle shifter keeps the line high
  a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SH_IDLE) |-> line);

  // R10: a disable returns the shifter to idle
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (state == SH_IDLE));

endmodule

// File: rtl/uart_tx_doneflag.sv
module uart_tx_doneflag (
  input  logic clk,
  input  logic rst_n,
  input  logic done_set,
  input  logic clr_req,
  output logic tx_done
);

  always_ff @(posedge clk) begin
    if (!rst_n)        tx_done <= 1'b0;
    else if (clr_req)  tx_done <= 1'b0;
    else if (done_set) tx_done <= 1'b1;
  end

  // R8: a clear request always wins
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !tx_done);

  // R7: completion sets the flag, which then holds
  a_r7_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_set && !clr_req) |=> tx_done);

  a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_set && !clr_req) |=> $stable(tx_done));

endmodule

// File: rtl/uart_tx_pinmux.sv
module uart_tx_pinmux (
  input  logic tx_en,
  input  logic line,
  input  logic gpio_out,
  input  logic gpio_oe,
  output logic pin_out,
  output logic pin_oe
);

  always_comb begin
    pin_out = tx_en ? line : gpio_out;
    pin_oe  = tx_en | gpio_oe;
  end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              nine_bit_mode,
  input  logic              tx_bit8,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tc_clr,
  input  logic              gpio_out,
  input  logic              gpio_oe,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              pin_out,
  output logic              pin_oe
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              wr_accept;
  logic              take;
  logic              done_set;
  logic              line;

  assign hold_empty = !hold_full;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .take(take), .hold_full(hold_full), .hold_data(hold_data),
    .wr_accept(wr_accept)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .nine_bit_mode(nine_bit_mode), .tx_bit8(tx_bit8),
    .hold_full(hold_full), .hold_data(hold_data),
    .take(take), .done_set(done_set), .line(line)
  );

  uart_tx_doneflag u_done (
    .clk(clk), .rst_n(rst_n), .done_set(done_set),
    .clr_req(tc_clr || wr_accept), .tx_done(tx_done)
  );

  uart_tx_pinmux u_pin (
    .tx_en(tx_en), .line(line), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R6/R7: completion is only reported with nothing queued
  a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> hold_empty);

endmodule

// File: tb/uart_tx_dbuf_tb.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb;

  localparam int DATA_W = 8;
  localparam int TDIV   = 8;

  typedef struct {
    logic [DATA_W-1:0] d;
    logic              b8;
    logic              nine;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic baud_tick = 0;
  logic tx_en = 0;
  logic nine_bit_mode = 0;
  logic tx_bit8 = 0;
  logic wr_valid = 0;
  logic wr_ready;
  logic [DATA_W-1:0] wr_data = '0;
  logic tc_clr = 0;
  logic gpio_out = 0;
  logic gpio_oe = 0;
  logic hold_empty, tx_done, pin_out, pin_oe;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  ticks_on = 0;
  bit  mon_mute = 0;
  bit  finished = 0;
  int  tcnt = 0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  uart_tx_dbuf #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .nine_bit_mode(nine_bit_mode), .tx_bit8(tx_bit8),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tc_clr(tc_clr), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .hold_empty(hold_empty), .tx_done(tx_done),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always @(negedge clk) begin
    if (!ticks_on) begin
      tcnt = 0;
      baud_tick <= 1'b0;
    end else begin
      tcnt = tcnt + 1;
      baud_tick <= (tcnt % TDIV == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  // driver: returns at the negedge after the accepting edge
  task automatic send(input logic [DATA_W-1:0] d, input bit push);
    item_t it;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    if (push) begin
      it.d = d; it.b8 = tx_bit8; it.nine = nine_bit_mode;
      exp_q.push_back(it);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // monitor: decodes the line once per bit and compares with the queue
  initial begin
    int st, nb, total;
    logic [15:0] acc;
    item_t cur;
    st = 0; nb = 0; total = 0; acc = '0;
    forever begin
      @(posedge clk);
      if (!baud_tick) continue;
      @(negedge clk);
      if (!tx_en || mon_mute) begin st = 0; continue; end
      if (st == 0) begin
        if (pin_out == 1'b0) begin
          if (exp_q.size() == 0) begin
            check(0, "R3 unexpected frame", 0, 1);
          end else begin
            cur = exp_q.pop_front();
            total = cur.nine ? DATA_W + 2 : DATA_W + 1;
            nb = 0; acc = '0; st = 1;
          end
        end
      end else begin
        acc[nb] = pin_out;
        nb++;
        if (nb == total) begin
          check(acc[DATA_W-1:0] == cur.d, "R3 frame data",
                int'(acc[DATA_W-1:0]), int'(cur.d));
          if (cur.nine)
            check(acc[DATA_W] == cur.b8, "R3 ninth bit", int'(acc[DATA_W]), int'(cur.b8));
          check(acc[total-1] == 1'b1, "R3 stop bit", int'(acc[total-1]), 1);
          st = 0;
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] pat;
    bit all_high;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9 / R2 with transmitter disabled
    check(hold_empty == 1, "R1 hold_empty reset", hold_empty, 1);
    check(tx_done == 0, "R1 tx_done reset", tx_done, 0);
    check(pin_oe == 0 && pin_out == 0, "R9 gpio passthrough", {pin_oe, pin_out}, 0);
    check(wr_ready == 0, "R2 ready low when disabled", wr_ready, 0);
    tx_en = 1'b1;
    @(negedge clk);
    check(pin_oe == 1 && pin_out == 1, "R11 idle high enabled", {pin_oe, pin_out}, 3);
    check(wr_ready == 1, "R2 ready when enabled and empty", wr_ready, 1);
    ticks_on = 1'b1;

    // R4 / R3 / R7: single 8-bit frame, bit by bit
    pat = 8'hA5;
    wait_tick();
    send(pat, 1);
    check(hold_empty == 0, "R2 holding occupied after accept", hold_empty, 0);
    @(negedge clk);
    check(hold_empty == 1, "R4 empty at load", hold_empty, 1);
    check(pin_out == 1, "R4 line high before tick", pin_out, 1);
    wait_tick();
    check(pin_out == 0, "R4 start bit on first tick", pin_out, 0);
    for (int b = 0; b < DATA_W; b++) begin
      wait_tick();
      check(pin_out == pat[b], "R3 lsb-first data", pin_out, pat[b]);
    end
    wait_tick();
    check(pin_out == 1 && tx_done == 0, "R7 stop on line, not done", {pin_out, tx_done}, 2);
    wait_tick();
    check(tx_done == 1, "R7 done after stop bit time", tx_done, 1);
    ticks(2);
    check(tx_done == 1 && pin_out == 1, "R7 done stays set", {tx_done, pin_out}, 3);

    // R8: clear strobe
    @(negedge clk); tc_clr = 1'b1;
    @(negedge clk); tc_clr = 1'b0;
    check(tx_done == 0, "R8 clear strobe", tx_done, 0);

    // R5 / R2: back-to-back with back-pressure
    wait_tick();
    send(8'h3C, 1);
    @(negedge clk);
    send(8'hC3, 1);
    check(hold_empty == 0, "R5 second char queued", hold_empty, 0);
    wait_tick();
    check(pin_out == 0, "R4 start of first", pin_out, 0);
    for (int i = 0; i < 3; i++) begin
      wr_valid = 1'b1; wr_data = 8'hFF;
      check(wr_ready == 0, "R2 ready low while full", wr_ready, 0);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    ticks(8);
    check(hold_empty == 0, "R5 still waiting before stop", hold_empty, 0);
    wait_tick();
    check(hold_empty == 1 && pin_out == 1, "R5 reload at stop bit", {hold_empty, pin_out}, 3);
    wait_tick();
    check(pin_out == 0 && tx_done == 0, "R5 next start without gap", {pin_out, tx_done}, 0);
    ticks(10);
    check(tx_done == 1, "R7 done after second frame", tx_done, 1);

    // R6: write while stop bit is on the line
    wait_tick();
    send(8'h5A, 1);
    check(tx_done == 0, "R8 write clears done", tx_done, 0);
    @(negedge clk);
    ticks(10);
    check(pin_out == 1, "R6 stop bit present", pin_out, 1);
    send(8'h0F, 1);
    @(negedge clk);
    check(hold_empty == 1, "R6 immediate load", hold_empty, 1);
    wait_tick();
    check(pin_out == 0 && tx_done == 0, "R6 start follows, no done", {pin_out, tx_done}, 0);
    ticks(10);
    check(tx_done == 1, "R7 done after R6 frame", tx_done, 1);

    // R3: 9-bit mode, ninth bit 1 then 0
    nine_bit_mode = 1'b1;
    for (int k = 0; k < 2; k++) begin
      tx_bit8 = (k == 0);
      wait_tick();
      send(k == 0 ? 8'h12 : 8'h34, 1);
      @(negedge clk);
      ticks(10);
      check(pin_out == tx_bit8, "R3 ninth bit position", pin_out, tx_bit8);
      wait_tick();
      check(pin_out == 1 && tx_done == 0, "R3 stop after ninth bit", {pin_out, tx_done}, 2);
      wait_tick();
      check(tx_done == 1, "R7 done in 9-bit mode", tx_done, 1);
    end
    nine_bit_mode = 1'b0;
    tx_bit8 = 1'b0;

    // R10 / R9: abort mid-frame with a pending character
    mon_mute = 1'b1;
    wait_tick();
    send(8'h00, 0);
    @(negedge clk);
    ticks(3);
    send(8'hEE, 0);
    check(hold_empty == 0, "R10 pending before abort", hold_empty, 0);
    tx_en = 1'b0; gpio_out = 1'b1; gpio_oe = 1'b0;
    @(negedge clk);
    check(hold_empty == 1 && wr_ready == 0, "R10 pending discarded", {hold_empty, wr_ready}, 2);
    check(pin_out == 1 && pin_oe == 0, "R9 gpio drives pin", {pin_out, pin_oe}, 2);
    gpio_out = 1'b0; gpio_oe = 1'b1;
    #1;
    check(pin_out == 0 && pin_oe == 1, "R9 gpio value and direction", {pin_out, pin_oe}, 1);
    @(negedge clk);
    tx_en = 1'b1; gpio_oe = 1'b0;
    #1;
    check(pin_out == 1 && pin_oe == 1, "R10 idle after re-enable", {pin_out, pin_oe}, 3);
    all_high = 1;
    for (int i = 0; i < 14; i++) begin
      wait_tick();
      if (pin_out != 1) all_high = 0;
    end
    check(all_high, "R10 nothing resumes", all_high, 1);
    mon_mute = 1'b0;
    send(8'h6B, 1);
    ticks(13);
    check(tx_done == 1, "R7 done after recovery frame", tx_done, 1);

    ticks(2);
    check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule